// File: doc/BRIEF.md
# Per-Channel Sample Loss Detector

This block watches a stream of 32-bit sample words arriving from an eight-channel acquisition source. Each word carries an 8-bit timestamp, a one-hot tag naming the channel the sample belongs to, and a 14-bit sample value. The block decodes the tag into a channel index and forwards the index and the sample one cycle later. It also remembers the last timestamp seen on every channel. The source advances a channel's timestamp by exactly one for each new sample on that channel. Any other step between two samples on the same channel therefore means that samples were dropped on the way.

When the block detects a gap, it raises a single-cycle loss pulse that names the channel. It also bumps a saturating 16-bit loss counter that belongs to that channel. A word whose tag is not exactly one-hot is reported as a format error and takes no further part. A start-of-stream strobe forgets every reference point and clears every counter, so a new acquisition starts clean.

Top module: `seq_gap_monitor`

## Requirements
- R1: While and after reset, out_valid_o, loss_pulse_o and fmt_err_o are 0 and every loss counter reads 0.
- R2: An accepted word has exactly one bit set in word_i[23:16]. Bit 16+n selects channel n. One cycle after such a word, out_valid_o is 1 for one cycle, out_chan_o is n and out_sample_o equals word_i[13:0].
- R3: The first accepted word on a channel after reset or start-of-stream stores word_i[31:24] as that channel's reference. It raises no loss.
- R4: A later word on the same channel whose timestamp equals the reference plus one, modulo 256, raises no loss. This includes the step from 255 to 0.
- R5: Any other timestamp step raises loss_pulse_o for one cycle, together with out_valid_o, with loss_chan_o = n. That channel's counter in loss_count_o[16n+15:16n] rises by one.
- R6: Every accepted word replaces its channel's reference with its own timestamp, including a word that raised a loss.
- R7: Channels are independent. A word on one channel never changes another channel's reference or counter.
- R8: A word whose tag has zero bits or more than one bit set raises fmt_err_o for one cycle, with out_valid_o low and no loss. It leaves every reference and counter unchanged.
- R9: A loss counter holds at 65535 once it gets there.
- R10: While sos_i is 1, the block clears all references and counters and ignores any word presented in that cycle. The cycle after sos_i, all counters read 0 and out_valid_o and fmt_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sos_i | input | 1 | Start-of-stream strobe, clears all channel history |
| word_valid_i | input | 1 | word_i holds a sample word this cycle |
| word_i | input | 32 | Sample word: timestamp [31:24], one-hot tag [23:16], sample [13:0] |
| out_valid_o | output | 1 | Decoded sample present |
| out_chan_o | output | 3 | Channel index of the decoded sample |
| out_sample_o | output | 14 | Decoded sample value |
| loss_pulse_o | output | 1 | One-cycle loss indication |
| loss_chan_o | output | 3 | Channel of the most recent loss |
| fmt_err_o | output | 1 | One-cycle malformed-tag indication |
| loss_count_o | output | 128 | Eight 16-bit saturating loss counters, channel n at [16n+15:16n] |

## Verification
A wrong stored reference stays hidden until the next word on the same channel. That word then raises a false loss pulse, or misses a real one, one cycle after it is presented. So each scenario ends with a follow-up word whose outcome depends on the stored timestamp. A corrupted counter or a cross-channel write shows at once on loss_count_o in the cycle after the offending word. Reading all eight counter fields after every scenario therefore exposes state that leaked into the wrong channel.

// File: rtl/seq_gap_pkg.sv
package seq_gap_pkg;

    localparam int NUM_CH   = 8;
    localparam int TS_W     = 8;
    localparam int SMP_W    = 14;
    localparam int WORD_W   = 32;
    localparam int TS_LSB   = 24;
    localparam int TAG_LSB  = 16;
    localparam int IDX_W    = $clog2(NUM_CH);

    typedef logic [TS_W-1:0]   ts_t;
    typedef logic [NUM_CH-1:0] tag_t;
    typedef logic [SMP_W-1:0]  smp_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic ok;
        idx_t idx;
        ts_t  ts;
        smp_t smp;
    } dec_word_t;

    function automatic logic tag_is_onehot(input tag_t t);
        return (t != '0) && ((t & (t - tag_t'(1))) == '0);
    endfunction

    function automatic idx_t tag_to_index(input tag_t t);
        idx_t r;
        r = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (t[i]) r = r | idx_t'(i);
        end
        return r;
    endfunction

    function automatic ts_t ts_succ(input ts_t t);
        return t + ts_t'(1);
    endfunction

endpackage

// File: rtl/seq_gap_decode.sv
module seq_gap_decode
    import seq_gap_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_word_t         dec_o
);
    tag_t tag;

    always_comb begin
        tag       = word_i[TAG_LSB +: NUM_CH];
        dec_o.ok  = tag_is_onehot(tag);
        dec_o.idx = tag_to_index(tag);
        dec_o.ts  = word_i[TS_LSB +: TS_W];
        dec_o.smp = word_i[SMP_W-1:0];
    end
endmodule

// File: rtl/seq_gap_slot.sv
module seq_gap_slot
    import seq_gap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             hit_i,
    input  ts_t              ts_i,
    output logic             loss_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ref_ok;
    ts_t  last_ts;

    always_comb begin
        loss_o = hit_i && ref_ok && (ts_i != ts_succ(last_ts));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ref_ok  <= 1'b0;
            last_ts <= '0;
            count_o <= '0;
        end else if (hit_i) begin
            ref_ok  <= 1'b1;
            last_ts <= ts_i;
            if (loss_o && count_o != CNT_MAX) begin
                count_o <= count_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_gap_monitor.sv
module seq_gap_monitor
    import seq_gap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sos_i,
    input  logic                    word_valid_i,
    input  logic [WORD_W-1:0]       word_i,
    output logic                    out_valid_o,
    output logic [IDX_W-1:0]        out_chan_o,
    output logic [SMP_W-1:0]        out_sample_o,
    output logic                    loss_pulse_o,
    output logic [IDX_W-1:0]        loss_chan_o,
    output logic                    fmt_err_o,
    output logic [NUM_CH*CNT_W-1:0] loss_count_o
);
    dec_word_t         dec;
    logic              take;
    logic              accept;
    logic              reject;
    logic [NUM_CH-1:0] loss_vec;

    seq_gap_decode u_decode (
        .word_i (word_i),
        .dec_o  (dec)
    );

    always_comb begin
        take   = word_valid_i && !sos_i;
        accept = take && dec.ok;
        reject = take && !dec.ok;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        seq_gap_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .clear_i (sos_i),
            .hit_i   (accept && (dec.idx == idx_t'(g))),
            .ts_i    (dec.ts),
            .loss_o  (loss_vec[g]),
            .count_o (loss_count_o[g*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o  <= 1'b0;
            out_chan_o   <= '0;
            out_sample_o <= '0;
            loss_pulse_o <= 1'b0;
            loss_chan_o  <= '0;
            fmt_err_o    <= 1'b0;
        end else begin
            out_valid_o  <= accept;
            fmt_err_o    <= reject;
            loss_pulse_o <= |loss_vec;
            if (accept) begin
                out_chan_o   <= dec.idx;
                out_sample_o <= dec.smp;
            end
            if (|loss_vec) begin
                loss_chan_o <= dec.idx;
            end
        end
    end
endmodule

// File: rtl/seq_gap_monitor_chk.sv
module seq_gap_monitor_chk
    import seq_gap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sos_i,
    input logic                    out_valid_o,
    input logic [IDX_W-1:0]        out_chan_o,
    input logic                    loss_pulse_o,
    input logic [IDX_W-1:0]        loss_chan_o,
    input logic                    fmt_err_o,
    input logic [NUM_CH*CNT_W-1:0] loss_count_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !loss_pulse_o && !fmt_err_o && loss_count_o == '0));

    a_r5_loss_with_sample: assert property (@(posedge clk) disable iff (rst)
        loss_pulse_o |-> (out_valid_o && loss_chan_o == out_chan_o));

    a_r8_fmt_exclusive: assert property (@(posedge clk) disable iff (rst)
        fmt_err_o |-> (!out_valid_o && !loss_pulse_o));

    a_r10_sos_clears: assert property (@(posedge clk) disable iff (rst)
        sos_i |=> (loss_count_o == '0 && !out_valid_o && !fmt_err_o));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
        a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(sos_i)) |->
                (loss_count_o[g*CNT_W +: CNT_W] == $past(loss_count_o[g*CNT_W +: CNT_W]) ||
                 loss_count_o[g*CNT_W +: CNT_W] == $past(loss_count_o[g*CNT_W +: CNT_W]) + 1'b1));
    end
endmodule

bind seq_gap_monitor seq_gap_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sos_i        (sos_i),
    .out_valid_o  (out_valid_o),
    .out_chan_o   (out_chan_o),
    .loss_pulse_o (loss_pulse_o),
    .loss_chan_o  (loss_chan_o),
    .fmt_err_o    (fmt_err_o),
    .loss_count_o (loss_count_o)
);

// File: tb/seq_gap_monitor_tb.sv
module seq_gap_monitor_tb;
    localparam int PERIOD = 10;
    localparam int CW     = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sos_i = 1'b0;
    logic         word_valid_i = 1'b0;
    logic [31:0]  word_i = '0;
    logic         out_valid_o;
    logic [2:0]   out_chan_o;
    logic [13:0]  out_sample_o;
    logic         loss_pulse_o;
    logic [2:0]   loss_chan_o;
    logic         fmt_err_o;
    logic [127:0] loss_count_o;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    seq_gap_monitor u_dut (
        .clk(clk), .rst(rst), .sos_i(sos_i), .word_valid_i(word_valid_i),
        .word_i(word_i), .out_valid_o(out_valid_o), .out_chan_o(out_chan_o),
        .out_sample_o(out_sample_o), .loss_pulse_o(loss_pulse_o),
        .loss_chan_o(loss_chan_o), .fmt_err_o(fmt_err_o), .loss_count_o(loss_count_o)
    );

    function automatic logic [31:0] mk(input int ch, input int ts, input int smp);
        return {8'(ts), 8'(1 << ch), 2'b00, 14'(smp)};
    endfunction

    function automatic logic [15:0] cnt(input int ch);
        return loss_count_o[ch*CW +: CW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one word for one cycle; outputs are sampled at the following negedge
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        word_valid_i = 1'b1;
        word_i = w;
        @(negedge clk);
        word_valid_i = 1'b0;
    endtask

    task automatic start_stream();
        @(negedge clk);
        sos_i = 1'b1;
        word_valid_i = 1'b1;
        word_i = mk(0, 9, 1);
        @(negedge clk);
        sos_i = 1'b0;
        word_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", out_valid_o, 0);
        chk("R1 loss_pulse", loss_pulse_o, 0);
        chk("R1 fmt_err", fmt_err_o, 0);
        chk("R1 counters", (loss_count_o == '0), 1);
    endtask

    task automatic t_decode_first();
        send(mk(5, 77, 14'h2ABC));
        chk("R2 valid", out_valid_o, 1);
        chk("R2 chan", out_chan_o, 5);
        chk("R2 sample", out_sample_o, 14'h2ABC);
        chk("R3 first no loss", loss_pulse_o, 0);
        @(negedge clk);
        chk("R2 valid one cycle", out_valid_o, 0);
    endtask

    task automatic t_sequence_and_wrap();
        send(mk(2, 254, 3));
        send(mk(2, 255, 4));
        chk("R4 step no loss", loss_pulse_o, 0);
        send(mk(2, 0, 5));
        chk("R4 wrap no loss", loss_pulse_o, 0);
        chk("R4 wrap counter", cnt(2), 0);
    endtask

    task automatic t_gap_and_resync();
        send(mk(3, 10, 1));
        send(mk(3, 13, 2));
        chk("R5 loss pulse", loss_pulse_o, 1);
        chk("R5 loss chan", loss_chan_o, 3);
        chk("R5 counter", cnt(3), 1);
        @(negedge clk);
        chk("R5 pulse one cycle", loss_pulse_o, 0);
        send(mk(3, 14, 3));
        chk("R6 resync no loss", loss_pulse_o, 0);
        chk("R6 counter held", cnt(3), 1);
        send(mk(3, 14, 3));
        chk("R5 repeated ts is loss", loss_pulse_o, 1);
        chk("R5 counter two", cnt(3), 2);
    endtask

    task automatic t_independence();
        send(mk(6, 40, 0));
        send(mk(1, 200, 0));
        send(mk(6, 41, 0));
        chk("R7 interleave no loss", loss_pulse_o, 0);
        send(mk(1, 100, 0));
        chk("R7 ch1 loss", loss_pulse_o, 1);
        chk("R7 ch1 count", cnt(1), 1);
        chk("R7 ch6 untouched", cnt(6), 0);
        chk("R7 ch3 untouched", cnt(3), 2);
    endtask

    task automatic t_format();
        send(mk(4, 60, 0));
        send({8'd99, 8'h00, 16'h0011});
        chk("R8 zero tag fmt", fmt_err_o, 1);
        chk("R8 zero tag no valid", out_valid_o, 0);
        send({8'd99, 8'h12, 16'h0011});
        chk("R8 two-hot fmt", fmt_err_o, 1);
        chk("R8 two-hot no loss", loss_pulse_o, 0);
        chk("R8 ch1 count kept", cnt(1), 1);
        send(mk(4, 61, 0));
        chk("R8 reference kept", loss_pulse_o, 0);
        chk("R8 fmt clears", fmt_err_o, 0);
    endtask

    task automatic t_sos();
        start_stream();
        chk("R10 counters cleared", (loss_count_o == '0), 1);
        chk("R10 word ignored", out_valid_o, 0);
        send(mk(3, 200, 0));
        chk("R10 ref cleared no loss", loss_pulse_o, 0);
        send(mk(0, 5, 0));
        chk("R10 ignored word set no ref", loss_pulse_o, 0);
    endtask

    task automatic t_saturate();
        start_stream();
        @(negedge clk);
        word_valid_i = 1'b1;
        word_i = mk(7, 0, 0);
        for (int i = 1; i <= 65537; i++) begin
            @(negedge clk);
            word_i = mk(7, (2 * i) % 256, 0);
        end
        @(negedge clk);
        word_valid_i = 1'b0;
        chk("R9 saturated", cnt(7), 16'hFFFF);
        chk("R9 others zero", cnt(6), 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode_first();
        t_sequence_and_wrap();
        t_gap_and_resync();
        t_independence();
        t_format();
        t_sos();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule